// File: doc/BRIEF.md
# Calendar Real-Time Clock

This peripheral keeps wall-clock time and calendar date in hardware. A prescaler divides the system clock down to a one-second tick. Each tick advances seconds, minutes and hours, and at midnight it advances the day of month, the weekday, the month and a 12-bit year. The day rollover follows month lengths and the Gregorian leap-year rule.

Software talks to the block over a plain 32-bit register bus made of a write strobe, a byte address, write data and combinational read data. Time and date are loaded through two separate set registers plus a year register. A load happens only through a handshake: freeze the counters, raise the load bit while they are frozen, drop it, then release. The live values are read from two current registers. These registers pack their fields differently from the set registers, and each one is updated in a single clock edge.

Top module: `cal_rtc`

## Requirements
- R1: With prescaler divisor CLK_DIV, the first tick after reset release occurs on the CLK_DIV-th rising clock edge, and ticks then repeat every CLK_DIV edges. Each tick advances seconds by one.
- R2: After reset the clock reads 00:00:00, with date year 2000, month 1, day 1 and weekday 6.
- R3: A write to byte offset 0x00 with bit 24 (freeze) and bit 25 (load) both set, where the previously stored bit 25 was clear, loads hour from [20:16], minute from [13:8] and second from [5:0] on that write's clock edge.
- R4: The same handshake at offset 0x04 loads month from [19:16] (bit 20 is ignored), weekday from [10:8] and day from [4:0]. In the same step it loads the year last written at offset 0x08, taken from bits [11:0].
- R5: While bit 24 of the stored time-set word is 1, time does not advance. While bit 24 of the stored date-set word is 1, a midnight carry leaves the date unchanged.
- R6: A load-bit write that is not a rising edge (bit 25 already stored as 1), or that has bit 24 clear, leaves the counters unchanged.
- R7: Seconds wrap after 59 and minutes wrap after 59, each carrying into the next field. Hours wrap after 23 and carry into the date.
- R8: The day wraps to 1 after the last day of the month. February has 29 days when the year is divisible by 400, or divisible by 4 and not by 100, and 28 days otherwise.
- R9: Month 12 wraps to 1 and increments the year, and year 4095 wraps to 0. Weekday codes run 1..7 with Sunday coded 7, and code 7 wraps to 1.
- R10: Reading offset 0x10 returns hour [20:16], minute [13:8] and second [5:0]. Reading offset 0x14 returns month [27:24], weekday [23:21], day [20:16] and year [11:0]. All other bits, and all other offsets, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |

## Verification
The hardest cases to reach are the day, month and year rollovers, because counting there from reset would take simulated days. The stimulus instead freezes both channels, loads a time of 23:59:59 and a chosen date through the full handshake, and releases them. It then polls the current-time register until the next tick and compares both current registers against a bench model of the calendar. The dates come from random years, months and weekdays, biased toward month ends, and are mixed with fixed leap-year, century and year-4095 cases.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;
  localparam int YEAR_W = 12;

  localparam logic [31:0] OFS_TSET  = 32'h00;
  localparam logic [31:0] OFS_DSET  = 32'h04;
  localparam logic [31:0] OFS_YSET  = 32'h08;
  localparam logic [31:0] OFS_TCUR  = 32'h10;
  localparam logic [31:0] OFS_DCUR  = 32'h14;

  localparam int BIT_FREEZE = 24;
  localparam int BIT_LOAD   = 25;

  typedef struct packed {
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } tod_t;

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [3:0]        month;
    logic [2:0]        wday;
    logic [4:0]        mday;
  } cdate_t;

  localparam tod_t   TOD_RST  = '{hour: 5'd0, min: 6'd0, sec: 6'd0};
  localparam cdate_t DATE_RST = '{year: 12'd2000, month: 4'd1, wday: 3'd6, mday: 5'd1};

  function automatic logic is_leap(input logic [YEAR_W-1:0] y);
    return ((y % 12'd4) == 12'd0) &&
           (((y % 12'd100) != 12'd0) || ((y % 12'd400) == 12'd0));
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] m, input logic [YEAR_W-1:0] y);
    case (m)
      4'd2:                     return is_leap(y) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
      default:                  return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_rtc_prescaler.sv
module cal_rtc_prescaler #(
  parameter int CLK_DIV = 100_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CLK_DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/cal_rtc_ctl.sv
module cal_rtc_ctl
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              pause_t_o,
  output logic              pause_d_o,
  output logic              load_t_o,
  output logic              load_d_o,
  output tod_t              ld_tod_o,
  output cdate_t            ld_date_o
);
  localparam int NCH = 2;
  localparam logic [ADDR_W-1:0] CH_OFS [NCH] = '{ADDR_W'(OFS_TSET), ADDR_W'(OFS_DSET)};

  logic [NCH-1:0] freeze_q, arm_q, load;
  logic [YEAR_W-1:0] year_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic hit;
    assign hit = wr_en_i && (addr_i == CH_OFS[ch]);
    // load on a rising load bit written together with freeze
    assign load[ch] = hit && wdata_i[BIT_FREEZE] && wdata_i[BIT_LOAD] && !arm_q[ch];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        freeze_q[ch] <= 1'b0;
        arm_q[ch]    <= 1'b0;
      end else if (hit) begin
        freeze_q[ch] <= wdata_i[BIT_FREEZE];
        arm_q[ch]    <= wdata_i[BIT_LOAD];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      year_q <= DATE_RST.year;
    else if (wr_en_i && addr_i == ADDR_W'(OFS_YSET))
      year_q <= wdata_i[YEAR_W-1:0];
  end

  assign pause_t_o = freeze_q[0];
  assign pause_d_o = freeze_q[1];
  assign load_t_o  = load[0];
  assign load_d_o  = load[1];

  assign ld_tod_o  = '{hour: wdata_i[20:16], min: wdata_i[13:8], sec: wdata_i[5:0]};
  assign ld_date_o = '{year: year_q, month: wdata_i[19:16], wday: wdata_i[10:8],
                       mday: wdata_i[4:0]};
endmodule

// File: rtl/cal_rtc_core.sv
module cal_rtc_core
  import cal_rtc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   pause_t_i,
  input  logic   pause_d_i,
  input  logic   load_t_i,
  input  logic   load_d_i,
  input  tod_t   ld_tod_i,
  input  cdate_t ld_date_i,
  output tod_t   tod_o,
  output cdate_t date_o
);
  tod_t   tod_q, tod_n;
  cdate_t date_q, date_n;
  logic   carry;

  always_comb begin
    tod_n  = tod_q;
    date_n = date_q;
    carry  = 1'b0;
    if (tick_i && !pause_t_i) begin
      if (tod_q.sec >= 6'd59) begin
        tod_n.sec = '0;
        if (tod_q.min >= 6'd59) begin
          tod_n.min = '0;
          if (tod_q.hour >= 5'd23) begin
            tod_n.hour = '0;
            carry      = 1'b1;
          end else tod_n.hour = tod_q.hour + 5'd1;
        end else tod_n.min = tod_q.min + 6'd1;
      end else tod_n.sec = tod_q.sec + 6'd1;
    end
    if (load_t_i) begin
      tod_n = ld_tod_i;
      carry = 1'b0;
    end

    if (carry && !pause_d_i) begin
      date_n.wday = (date_q.wday >= 3'd7) ? 3'd1 : date_q.wday + 3'd1;
      if (date_q.mday >= month_len(date_q.month, date_q.year)) begin
        date_n.mday = 5'd1;
        if (date_q.month >= 4'd12) begin
          date_n.month = 4'd1;
          date_n.year  = date_q.year + 1'b1;
        end else date_n.month = date_q.month + 4'd1;
      end else date_n.mday = date_q.mday + 5'd1;
    end
    if (load_d_i) date_n = ld_date_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tod_q  <= TOD_RST;
      date_q <= DATE_RST;
    end else begin
      tod_q  <= tod_n;
      date_q <= date_n;
    end
  end

  assign tod_o  = tod_q;
  assign date_o = date_q;
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int CLK_DIV = 100_000_000,
  parameter int ADDR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  logic   tick, pause_t, pause_d, load_t, load_d;
  tod_t   ld_tod, tod;
  cdate_t ld_date, date;

  cal_rtc_prescaler #(.CLK_DIV(CLK_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  cal_rtc_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .pause_t_o(pause_t),
    .pause_d_o(pause_d),
    .load_t_o (load_t),
    .load_d_o (load_d),
    .ld_tod_o (ld_tod),
    .ld_date_o(ld_date)
  );

  cal_rtc_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .pause_t_i(pause_t),
    .pause_d_i(pause_d),
    .load_t_i (load_t),
    .load_d_i (load_d),
    .ld_tod_i (ld_tod),
    .ld_date_i(ld_date),
    .tod_o    (tod),
    .date_o   (date)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_TCUR)) begin
      rdata_o[20:16] = tod.hour;
      rdata_o[13:8]  = tod.min;
      rdata_o[5:0]   = tod.sec;
    end else if (addr_i == ADDR_W'(OFS_DCUR)) begin
      rdata_o[27:24] = date.month;
      rdata_o[23:21] = date.wday;
      rdata_o[20:16] = date.mday;
      rdata_o[11:0]  = date.year;
    end
  end
endmodule

// File: rtl/cal_rtc_checker.sv
module cal_rtc_checker
  import cal_rtc_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int ADDR_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick,
  input logic              pause_t,
  input logic              load_t,
  input logic              load_d,
  input tod_t              ld_tod,
  input tod_t              tod,
  input cdate_t            date,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o
);
  if (CLK_DIV > 1) begin : g_spacing
    a_r1_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick |=> !tick);
  end

  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !load_t) |=> $stable(tod));

  a_r3_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_t |=> (tod == $past(ld_tod)));

  a_r5_freeze_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_t && !load_t) |=> $stable(tod));

  a_r7_date_only_midnight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_d && !(tick && !pause_t && !load_t && tod.sec >= 6'd59 &&
                  tod.min >= 6'd59 && tod.hour >= 5'd23)) |=> $stable(date));

  a_r10_time_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_TCUR)) |->
      (rdata_o[31:21] == '0 && rdata_o[15:14] == '0 && rdata_o[7:6] == '0));

  a_r10_date_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_DCUR)) |-> (rdata_o[31:28] == '0 && rdata_o[15:12] == '0));
endmodule

bind cal_rtc cal_rtc_checker #(.CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick   (tick),
  .pause_t(pause_t),
  .load_t (load_t),
  .load_d (load_d),
  .ld_tod (ld_tod),
  .tod    (tod),
  .date   (date),
  .addr_i (addr_i),
  .rdata_o(rdata_o)
);

// File: tb/cal_rtc_tb.sv
module cal_rtc_tb;
  localparam int DIV = 4;
  localparam int AW  = 5;
  localparam logic [31:0] FRZ = 32'h0100_0000;
  localparam logic [31:0] LDB = 32'h0200_0000;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cal_rtc #(.CLK_DIV(DIV), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a[AW-1:0]; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    addr = a[AW-1:0];
    #1 d = rdata;
  endtask

  function automatic logic [31:0] tset(int h, int m, int s);
    return 32'((h << 16) | (m << 8) | s);
  endfunction
  function automatic logic [31:0] dset(int mo, int wd, int md);
    return 32'((mo << 16) | (wd << 8) | md);
  endfunction
  function automatic logic [31:0] drb(int y, int mo, int wd, int md);
    return 32'((mo << 24) | (wd << 21) | (md << 16) | y);
  endfunction

  function automatic bit leap(int y);
    return (y % 400 == 0) || ((y % 4 == 0) && (y % 100 != 0));
  endfunction
  function automatic int mlen(int mo, int y);
    if (mo == 2) return leap(y) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  // freeze time, load date and year, release date; time left loaded but frozen
  task automatic load_all(int h, int m, int s, int y, int mo, int wd, int md);
    wr(32'h00, tset(h, m, s) | FRZ);
    wr(32'h08, 32'(y));
    wr(32'h04, dset(mo, wd, md) | FRZ);
    wr(32'h04, dset(mo, wd, md) | FRZ | LDB);
    wr(32'h04, dset(mo, wd, md) | FRZ);
    wr(32'h04, dset(mo, wd, md));
    wr(32'h00, tset(h, m, s) | FRZ | LDB);
    wr(32'h00, tset(h, m, s) | FRZ);
  endtask

  task automatic wait_tick(input logic [31:0] base, output logic [31:0] t);
    t = base;
    for (int i = 0; i < 4 * DIV && t == base; i++) begin
      @(negedge clk);
      rd(32'h10, t);
    end
  endtask

  // one-second step from 23:59:59 on the given date
  task automatic midnight(int y, int mo, int wd, int md, string req);
    logic [31:0] t, d;
    int ny = y, nmo = mo, nmd = md + 1, nwd = (wd == 7) ? 1 : wd + 1;
    if (nmd > mlen(mo, y)) begin
      nmd = 1;
      nmo = mo + 1;
      if (nmo > 12) begin nmo = 1; ny = (y + 1) % 4096; end
    end
    load_all(23, 59, 59, y, mo, wd, md);
    rd(32'h14, d);
    chk({req, " loaded date"}, d, drb(y, mo, wd, md));
    wr(32'h00, tset(23, 59, 59));
    wait_tick(tset(23, 59, 59), t);
    chk({req, " time wrap (R7)"}, t, tset(0, 0, 0));
    rd(32'h14, d);
    chk({req, " next date"}, d, drb(ny, nmo, nwd, nmd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] t, d, t2;
    int edges;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    rd(32'h10, t); chk("R2 reset time", t, 32'h0);
    rd(32'h14, d); chk("R2 reset date", d, drb(2000, 1, 6, 1));
    // R1 tick timing
    edges = 0;
    while (t == 0 && edges < 10 * DIV) begin
      @(posedge clk); edges++;
      #1 rd(32'h10, t);
    end
    chk("R1 first tick edge", 32'(edges), 32'(DIV));
    while (t == 1 && edges < 10 * DIV) begin
      @(posedge clk); edges++;
      #1 rd(32'h10, t);
    end
    chk("R1 second tick edge", 32'(edges), 32'(2 * DIV));
    chk("R1 seconds value", t, 32'd2);
    // R10 other offsets
    rd(32'h00, d); chk("R10 offset 0x00 reads zero", d, 0);
    rd(32'h0C, d); chk("R10 offset 0x0C reads zero", d, 0);
    // R3 time load, R5 freeze
    load_all(13, 45, 30, 2024, 5, 3, 17);
    rd(32'h10, t); chk("R3 time loaded", t, tset(13, 45, 30));
    rd(32'h14, d); chk("R4 date and year loaded", d, drb(2024, 5, 3, 17));
    repeat (5 * DIV) @(negedge clk);
    rd(32'h10, t); chk("R5 time frozen", t, tset(13, 45, 30));
    // R6 repeated load bit while already armed: no load
    wr(32'h00, tset(1, 2, 3) | FRZ | LDB);
    wr(32'h00, tset(4, 5, 6) | FRZ | LDB);
    rd(32'h10, t); chk("R6 non-rising load ignored", t, tset(1, 2, 3));
    wr(32'h00, tset(1, 2, 3) | FRZ);
    // R6 load bit without freeze on date: no load (time frozen so date still)
    wr(32'h04, dset(9, 1, 9) | LDB);
    rd(32'h14, d); chk("R6 load without freeze ignored", d, drb(2024, 5, 3, 17));
    wr(32'h04, dset(9, 1, 9));
    // R4 month bit 20 ignored
    wr(32'h04, dset(16 + 7, 2, 4) | FRZ);
    wr(32'h04, dset(16 + 7, 2, 4) | FRZ | LDB);
    wr(32'h04, dset(16 + 7, 2, 4));
    rd(32'h14, d); chk("R4 month bit 20 ignored", d, drb(2024, 7, 2, 4));
    // R7 minute/hour carry
    wr(32'h00, tset(10, 59, 59) | FRZ | LDB);
    wr(32'h00, tset(10, 59, 59));
    wait_tick(tset(10, 59, 59), t);
    chk("R7 hour carry", t, tset(11, 0, 0));
    // R5 date freeze on midnight carry
    load_all(23, 59, 59, 2023, 6, 4, 30);
    wr(32'h04, FRZ);
    wr(32'h00, tset(23, 59, 59));
    wait_tick(tset(23, 59, 59), t);
    chk("R5 time runs", t, 0);
    rd(32'h14, d); chk("R5 date frozen at midnight", d, drb(2023, 6, 4, 30));
    wr(32'h04, 0);
    // directed rollovers
    midnight(2023, 2, 2, 28, "R8 non-leap Feb");
    midnight(2024, 2, 3, 28, "R8 leap Feb 28");
    midnight(2024, 2, 4, 29, "R8 leap Feb 29");
    midnight(1900, 2, 3, 28, "R8 century non-leap");
    midnight(2000, 2, 1, 28, "R8 400-year leap");
    midnight(2023, 4, 7, 30, "R8 30-day month");
    midnight(2023, 12, 7, 31, "R9 year wrap and Sunday wrap");
    midnight(4095, 12, 5, 31, "R9 year 4095 wraps");
    // random dates, biased to month ends
    for (int i = 0; i < 40; i++) begin
      int y = $urandom_range(4095);
      int mo = $urandom_range(12, 1);
      int wd = $urandom_range(7, 1);
      int md = ($urandom_range(1) == 1) ? mlen(mo, y) : $urandom_range(mlen(mo, y), 1);
      midnight(y, mo, wd, md, "R8 R9 random date");
    end
    // random running time
    for (int i = 0; i < 10; i++) begin
      int h = $urandom_range(23), m = $urandom_range(59), s = $urandom_range(59);
      int ns = s + 1, nm = m, nh = h;
      if (ns == 60) begin ns = 0; nm++; end
      if (nm == 60) begin nm = 0; nh++; end
      if (nh == 24) nh = 0;
      wr(32'h00, tset(h, m, s) | FRZ);
      wr(32'h00, tset(h, m, s) | FRZ | LDB);
      wr(32'h00, tset(h, m, s));
      wait_tick(tset(h, m, s), t2);
      chk("R7 R10 random time step", t2, tset(nh, nm, ns));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule